// File: doc/BRIEF.md
# SPI Slave Pause Controller

This block runs the pause function of a serial memory slave. Chip select, serial clock and the pause pin come from the pads. Each passes through a synchroniser into a faster system clock. From these samples the block tells the serial shift logic when it may shift. It also tells the shift logic when to freeze its state, and when the data output driver may be enabled. When chip select is released in the middle of a pause, it also sends a reset pulse to the serial front end.

A pause is aligned to the serial clock being low. If the pause pin changes while the clock is high, the change waits for the next falling clock. After a pause ends through deselection, the block returns to service only in one order: first the pause pin goes high while the device is deselected, then chip select falls again.

Input bits are taken on the rising serial clock and output bits change after the falling one. The idle clock level may be either low or high (SPI mode 0 or mode 3). The block has no connection to the command decoder or to any internal write or erase cycle, so a pause cannot stop such a cycle.

Top module: `spi_pause_ctrl`

## Requirements
- R1: A low pause pin while chip select is high has no effect: freeze stays 0. If chip select then falls with the pause pin high, the block enters normal service with dout_oe = 1.
- R2: With chip select low and the serial clock low, a falling pause pin raises freeze and lowers dout_oe within SYNC_STAGES+2 system clocks.
- R3: With chip select low and the serial clock high, a falling pause pin leaves freeze at 0 and dout_oe at 1 until the serial clock goes low. After that, freeze rises.
- R4: During a pause with the serial clock low, a rising pause pin clears freeze and restores dout_oe.
- R5: During a pause with the serial clock high, a rising pause pin keeps freeze at 1 until the serial clock goes low.
- R6: While freeze is 1, dout_oe is 0, and serial clock edges produce no sck_rise or sck_fall strobe.
- R7: Chip select rising during a pause gives exactly one fe_reset pulse, one system clock long, and clears freeze.
- R8: After such a reset, dout_oe stays 0 until the pause pin is seen high while chip select is high and chip select then falls again. A chip select fall with the pause pin still low does not restore service.
- R9: dout_oe is 0 whenever the synchronised chip select is high.
- R10: In normal service, each rising serial clock gives one sck_rise strobe and each falling one gives one sck_fall strobe, from either idle clock level.
- R11: During and right after reset, freeze, dout_oe, fe_reset, sck_rise and sck_fall are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select from the pad, active low, asynchronous |
| sck_pin | input | 1 | Serial clock from the pad, asynchronous |
| hold_n_pin | input | 1 | Pause request from the pad, active low, asynchronous |
| freeze | output | 1 | Shift logic must keep its state |
| dout_oe | output | 1 | Enable for the serial data output driver |
| fe_reset | output | 1 | One-cycle reset for the serial front end |
| sck_rise | output | 1 | Strobe: take an input bit |
| sck_fall | output | 1 | Strobe: present the next output bit |

## Verification
The hardest situation to reach is the lockout after deselection during a pause. Getting there needs a pause that is actually in force, then a chip select release, then a reselection attempt while the pause pin is still low. The stimulus table walks that exact order. It first enters a pause through the delayed path, with the serial clock high when the pause pin falls. It then releases chip select, reselects with the pause pin still low, and raises the pause pin before it deselects and reselects. Directed runs then toggle the serial clock inside and outside a pause and count the strobes.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;

    typedef enum logic [2:0] {
        PS_DESEL    = 3'd0,
        PS_RUN      = 3'd1,
        PS_WAIT_IN  = 3'd2,
        PS_PAUSED   = 3'd3,
        PS_WAIT_OUT = 3'd4,
        PS_LOCKOUT  = 3'd5
    } pause_state_e;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic hold_n;
    } pad_bits_t;

    localparam int PAD_W = $bits(pad_bits_t);

    function automatic logic state_frozen(pause_state_e s);
        return (s == PS_PAUSED) || (s == PS_WAIT_OUT);
    endfunction

    function automatic logic state_serving(pause_state_e s);
        return (s == PS_RUN) || (s == PS_WAIT_IN);
    endfunction

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= rst_val;
                    else     chain[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= rst_val;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sck_edges.sv
module sck_edges (
    input  logic clk,
    input  logic rst,
    input  logic sck_s,
    output logic rise,
    output logic fall
);
    logic sck_prev;

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= sck_s;
    end

    assign rise = sck_s & ~sck_prev;
    assign fall = ~sck_s & sck_prev;
endmodule

// File: rtl/pause_fsm.sv
module pause_fsm
    import spi_pause_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  pad_bits_t    pads,
    input  logic         rise_raw,
    input  logic         fall_raw,
    output pause_state_e state,
    output logic         freeze,
    output logic         dout_oe,
    output logic         fe_reset,
    output logic         sck_rise,
    output logic         sck_fall
);
    pause_state_e nxt;
    logic         selected;

    assign selected = ~pads.cs_n;

    always_comb begin
        nxt = state;
        unique case (state)
            PS_DESEL: begin
                if (selected) nxt = PS_RUN;
            end
            PS_RUN: begin
                if (!selected)        nxt = PS_DESEL;
                else if (!pads.hold_n) nxt = pads.sck ? PS_WAIT_IN : PS_PAUSED;
            end
            PS_WAIT_IN: begin
                if (!selected)        nxt = PS_DESEL;
                else if (pads.hold_n) nxt = PS_RUN;
                else if (!pads.sck)   nxt = PS_PAUSED;
            end
            PS_PAUSED: begin
                if (!selected)        nxt = PS_LOCKOUT;
                else if (pads.hold_n) nxt = pads.sck ? PS_WAIT_OUT : PS_RUN;
            end
            PS_WAIT_OUT: begin
                if (!selected)         nxt = PS_LOCKOUT;
                else if (!pads.hold_n) nxt = PS_PAUSED;
                else if (!pads.sck)    nxt = PS_RUN;
            end
            PS_LOCKOUT: begin
                if (!selected && pads.hold_n) nxt = PS_DESEL;
            end
            default: nxt = PS_DESEL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_DESEL;
        else     state <= nxt;
    end

    logic live;
    assign live     = (state == PS_RUN) && selected && pads.hold_n;
    assign freeze   = state_frozen(state);
    assign dout_oe  = state_serving(state) && selected;
    assign fe_reset = state_frozen(state) && !selected;
    assign sck_rise = live && rise_raw;
    assign sck_fall = live && fall_raw;

    // R2
    paused_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_RUN && selected && !pads.hold_n && !pads.sck) |=> freeze);

    // R3
    wait_high_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_RUN && selected && !pads.hold_n && pads.sck) |=> !freeze);

    // R5
    exit_waits_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && selected && pads.hold_n && pads.sck) |=> freeze);

    // R6
    no_strobe_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |-> (!sck_rise && !sck_fall && !dout_oe));

    // R7
    single_fe_reset_chk: assert property (@(posedge clk) disable iff (rst)
        fe_reset |=> (!fe_reset && state == PS_LOCKOUT));

    // R8
    lockout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_LOCKOUT && !pads.hold_n) |=> !dout_oe);

    // R9
    oe_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        pads.cs_n |-> !dout_oe);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!freeze && !dout_oe && !fe_reset && !sck_rise && !sck_fall));
endmodule

// File: rtl/spi_pause_ctrl.sv
module spi_pause_ctrl
    import spi_pause_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic hold_n_pin,
    output logic freeze,
    output logic dout_oe,
    output logic fe_reset,
    output logic sck_rise,
    output logic sck_fall
);
    localparam pad_bits_t PAD_IDLE = '{cs_n: 1'b1, sck: 1'b0, hold_n: 1'b1};

    pad_bits_t    raw_pads;
    pad_bits_t    sync_pads;
    logic [PAD_W-1:0] sync_bus;
    logic         rise_raw, fall_raw;
    pause_state_e state;

    assign raw_pads = '{cs_n: cs_n_pin, sck: sck_pin, hold_n: hold_n_pin};

    pad_sync #(.STAGES(SYNC_STAGES), .W(PAD_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .din     (raw_pads),
        .rst_val (PAD_IDLE),
        .dout    (sync_bus)
    );
    assign sync_pads = sync_bus;

    sck_edges u_edges (
        .clk   (clk),
        .rst   (rst),
        .sck_s (sync_pads.sck),
        .rise  (rise_raw),
        .fall  (fall_raw)
    );

    pause_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pads     (sync_pads),
        .rise_raw (rise_raw),
        .fall_raw (fall_raw),
        .state    (state),
        .freeze   (freeze),
        .dout_oe  (dout_oe),
        .fe_reset (fe_reset),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );
endmodule

// File: tb/sim_spi_pause_ctrl.sv
module sim_spi_pause_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n_pin = 1'b1, sck_pin = 1'b0, hold_n_pin = 1'b1;
    logic freeze, dout_oe, fe_reset, sck_rise, sck_fall;

    int checks = 0;
    int fails  = 0;
    int n_rise = 0, n_fall = 0, n_fer = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    spi_pause_ctrl u0 (
        .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
        .hold_n_pin(hold_n_pin), .freeze(freeze), .dout_oe(dout_oe),
        .fe_reset(fe_reset), .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    always @(negedge clk) begin
        cyc++;
        if (sck_rise) n_rise++;
        if (sck_fall) n_fall++;
        if (fe_reset) n_fer++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {cs_n, sck, hold_n, exp_freeze, exp_oe}
    localparam int NV = 17;
    localparam logic [4:0] VEC [NV] = '{
        5'b10100,  // deselected
        5'b00101,  // R1 select -> service
        5'b00010,  // R2 pause with clk low
        5'b01010,  // R6 clk high inside pause
        5'b01110,  // R5 release waits for clk low
        5'b00101,  // R5 clk low ends pause
        5'b01101,  // clk high serving
        5'b01001,  // R3 pause waits
        5'b00010,  // R3 clk low starts pause
        5'b10000,  // R7 deselect in pause
        5'b00000,  // R8 reselect with pause low: locked
        5'b00100,  // R8 pause high but still selected: locked
        5'b10100,  // R8 deselect with pause high
        5'b00101,  // R8 reselect: service
        5'b10000,  // R9 deselect
        5'b10000,  // R1 pause low while deselected (same as above with hold low)
        5'b00101   // R1 select with pause high
    };

    initial begin : watchdog
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        settle(3);
        // R11 reset state
        chk("R11 freeze", freeze, 0);
        chk("R11 dout_oe", dout_oe, 0);
        chk("R11 fe_reset", fe_reset, 0);
        rst = 1'b0;
        settle(1);
        chk("R11 oe after reset", dout_oe, 0);

        for (int i = 0; i < NV; i++) begin
            cs_n_pin   = VEC[i][4];
            sck_pin    = VEC[i][3];
            hold_n_pin = (i == 15) ? 1'b0 : VEC[i][2];
            settle(6);
            chk($sformatf("vec%0d freeze", i), freeze, VEC[i][1]);
            chk($sformatf("vec%0d dout_oe", i), dout_oe, VEC[i][0]);
            if (i == 9) chk("R7 fe_reset pulses", n_fer, 1);
        end
        chk("R7 single pulse overall", n_fer, 1);

        // R10 mode 0 strobes in service
        n_rise = 0; n_fall = 0;
        for (int k = 0; k < 3; k++) begin
            sck_pin = 1'b1; settle(4);
            sck_pin = 1'b0; settle(4);
        end
        chk("R10 rises mode0", n_rise, 3);
        chk("R10 falls mode0", n_fall, 3);

        // R10 mode 3: idle high
        sck_pin = 1'b1; settle(5);
        n_rise = 0; n_fall = 0;
        for (int k = 0; k < 2; k++) begin
            sck_pin = 1'b0; settle(4);
            sck_pin = 1'b1; settle(4);
        end
        chk("R10 rises mode3", n_rise, 2);
        chk("R10 falls mode3", n_fall, 2);

        // R6 no strobes during a pause (clk high -> wait for low first)
        hold_n_pin = 1'b0; settle(5);
        chk("R3 no freeze while clk high", freeze, 0);
        sck_pin = 1'b0; settle(5);
        chk("R3 freeze after clk low", freeze, 1);
        n_rise = 0; n_fall = 0;
        for (int k = 0; k < 3; k++) begin
            sck_pin = 1'b1; settle(4);
            sck_pin = 1'b0; settle(4);
        end
        chk("R6 no rises in pause", n_rise, 0);
        chk("R6 no falls in pause", n_fall, 0);
        chk("R6 oe low in pause", dout_oe, 0);

        // R4 release with clk low
        hold_n_pin = 1'b1; settle(5);
        chk("R4 freeze cleared", freeze, 0);
        chk("R4 oe restored", dout_oe, 1);

        // R2 latency bound: SYNC_STAGES+2 cycles
        hold_n_pin = 1'b0; settle(4);
        chk("R2 freeze within latency", freeze, 1);
        hold_n_pin = 1'b1; settle(5);

        // R9 oe off when deselected
        cs_n_pin = 1'b1; settle(5);
        chk("R9 oe off", dout_oe, 0);
        chk("R7 no extra fe_reset", n_fer, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule